// File: doc/BRIEF.md
# Write-Masked GPIO Register Bank

This block is the register file of a 32-pin general-purpose I/O bank. Every 32-bit logical register is split into two 16-bit halves at consecutive word addresses: the lower half (pins 0–15) sits at the register's base offset and the upper half (pins 16–31) at base+4. On each write, data bits 31:16 are per-bit enables for data bits 15:0. A driver can therefore set or clear any single pin in one bus write, with no read-modify-write and no lock shared between software contexts.

The bank stores eight configuration registers: output data, direction, interrupt enable, interrupt mask, interrupt type, interrupt polarity, both-edge select and debounce enable. It drives the pad output and output-enable vectors and exports the six interrupt settings to separate detection logic. It also offers read-only views of:
- the synchronised pad inputs;
- the raw interrupt status supplied by the detection logic;
- that status with masked pins cleared;
- a constant version word.

A write-only end-of-interrupt register turns each write into a one-cycle, per-pin clear pulse toward the detection logic.

The request side is a valid/ready channel whose ready output is held high: the bank accepts a request on every clock edge where valid is high and never applies back-pressure. A read produces exactly one response beat, with its valid flag high, in the cycle after the request is accepted. The response channel has no ready input, so the consumer must take that beat. A write produces no response.

Top module: `gpio_wmask_regs`

## Requirements
- R1: After reset every stored register is zero. pad_oe and pad_out are all zero, the interrupt setting outputs are zero, and reads of the stored registers return zero.
- R2: On a write to a stored half, stored bit i takes data bit i when data bit 16+i is 1. It keeps its value when data bit 16+i is 0, so a write with bits 31:16 all zero changes nothing.
- R3: The half at the base offset holds pins 0–15 and the half at base+4 holds pins 16–31. A read of either half returns its 16 bits in data bits 15:0, with bits 31:16 zero.
- R4: Stored register base offsets are: data 0x00, direction 0x08, interrupt enable 0x10, mask 0x18, type 0x20, polarity 0x28, both-edge 0x30, debounce 0x38.
- R5: pad_oe equals the direction register, where 1 means the pin drives. pad_out equals the data register. Both change only in the cycle after a write to their own register.
- R6: A read at 0x70 (pins 0–15) or 0x74 (pins 16–31) returns the pad input levels after a two-flop synchroniser. A pad change is visible to a read accepted two or more cycles after the change.
- R7: Reads at 0x58/0x5C return irq_raw. Reads at 0x50/0x54 return irq_raw with every pin whose mask bit is 1 forced to 0.
- R8: A write to 0x60 or 0x64 drives eoi_clr high for exactly the next cycle, on the pins of that half whose enable and data bits are both 1. Reads of 0x60/0x64 return zero.
- R9: A read at 0x78 returns 0x01000C2B. Reads at 0x7C and at any other unmapped offset return zero.
- R10: req_ready is always 1. rsp_valid is high in exactly the cycle after an accepted read, and a write produces no response beat.
- R11: irq_en, irq_mask, irq_type, irq_pol, irq_both and dbnc_en continuously show their stored 32-bit registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, held at 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address, word aligned |
| req_wdata | input | 32 | Write data: 31:16 enables, 15:0 values |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| pad_in | input | 32 | Asynchronous pad levels |
| irq_raw | input | 32 | Raw interrupt status from detection logic |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq_en | output | 32 | Interrupt enable setting |
| irq_mask | output | 32 | Interrupt mask setting |
| irq_type | output | 32 | Interrupt type setting |
| irq_pol | output | 32 | Interrupt polarity setting |
| irq_both | output | 32 | Both-edge setting |
| dbnc_en | output | 32 | Debounce enable setting |
| eoi_clr | output | 32 | One-cycle per-pin interrupt clear pulse |

## Verification
The bound checker examines every cycle and confirms four things:
- rsp_valid appears only after an accepted read, and an idle or write cycle never produces one.
- eoi_clr pulses only after a write to the end-of-interrupt word.
- pad_oe and pad_out stay frozen unless their own register was just written.
- A write with all enables cleared leaves the output data unchanged.

Only the bench's scenarios can show the rest:
- the exact bit placement of the two halves;
- the address map and the version constant;
- the synchroniser latency;
- the masked-status arithmetic;
- the width of the clear pulse and the pins it covers.

// File: rtl/gpio_wm_pkg.sv
package gpio_wm_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int NSTORE = 8;

  typedef enum logic [2:0] {
    ST_DATA = 3'd0,
    ST_DIR  = 3'd1,
    ST_IEN  = 3'd2,
    ST_IMSK = 3'd3,
    ST_ITYP = 3'd4,
    ST_IPOL = 3'd5,
    ST_IBTH = 3'd6,
    ST_DBNC = 3'd7
  } store_idx_e;

  localparam logic [7:0] OFS_MSTAT = 8'h50;
  localparam logic [7:0] OFS_RSTAT = 8'h58;
  localparam logic [7:0] OFS_EOI   = 8'h60;
  localparam logic [7:0] OFS_EXT   = 8'h70;
  localparam logic [7:0] OFS_VER   = 8'h78;

  localparam logic [WORD_W-1:0] VERSION_ID = 32'h0100_0C2B;
endpackage

// File: rtl/gpio_wm_half.sv
module gpio_wm_half #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wen,
  input  logic [W-1:0] wval,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              q[b] <= 1'b0;
      else if (we && wen[b])   q[b] <= wval[b];
    end
  end
endmodule

// File: rtl/gpio_wm_sync.sv
module gpio_wm_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_wmask_regs.sv
module gpio_wmask_regs
  import gpio_wm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  input  logic [WORD_W-1:0] pad_in,
  input  logic [WORD_W-1:0] irq_raw,
  output logic [WORD_W-1:0] pad_out,
  output logic [WORD_W-1:0] pad_oe,
  output logic [WORD_W-1:0] irq_en,
  output logic [WORD_W-1:0] irq_mask,
  output logic [WORD_W-1:0] irq_type,
  output logic [WORD_W-1:0] irq_pol,
  output logic [WORD_W-1:0] irq_both,
  output logic [WORD_W-1:0] dbnc_en,
  output logic [WORD_W-1:0] eoi_clr
);
  localparam int SLOT_W = ADDR_W - 3;
  localparam int IDX_W  = $clog2(NSTORE);

  logic [NSTORE-1:0][WORD_W-1:0] store_q;
  logic [WORD_W-1:0]             pad_sync;
  logic [WORD_W-1:0]             masked_stat;
  logic [WORD_W-1:0]             rd_word;
  logic [HALF_W-1:0]             wr_en_bits;
  logic [HALF_W-1:0]             wr_val_bits;
  logic [SLOT_W-1:0]             slot;
  logic                          hi_half;
  logic                          wr_acc;
  logic                          rd_acc;
  logic                          in_store;
  logic                          unused_addr;

  assign req_ready   = 1'b1;
  assign wr_acc      = req_valid && req_write;
  assign rd_acc      = req_valid && !req_write;
  assign slot        = req_addr[ADDR_W-1:3];
  assign hi_half     = req_addr[2];
  assign in_store    = (slot < SLOT_W'(NSTORE));
  assign wr_en_bits  = req_wdata[WORD_W-1:HALF_W];
  assign wr_val_bits = req_wdata[HALF_W-1:0];
  assign unused_addr = ^req_addr[1:0];

  function automatic logic [SLOT_W-1:0] slot_of(input logic [7:0] ofs);
    return SLOT_W'(ofs >> 3);
  endfunction

  function automatic logic [WORD_W-1:0] pick_half(input logic [WORD_W-1:0] v,
                                                  input logic            hi);
    return hi ? {{HALF_W{1'b0}}, v[WORD_W-1:HALF_W]}
              : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  // Stored registers: one write-masked half per (register, half) pair
  for (genvar k = 0; k < NSTORE; k++) begin : g_reg
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic we_kh;
      assign we_kh = wr_acc && in_store && (slot[IDX_W-1:0] == IDX_W'(k)) &&
                     (hi_half == h[0]);
      gpio_wm_half #(.W(HALF_W)) u_half (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we_kh),
        .wen  (wr_en_bits),
        .wval (wr_val_bits),
        .q    (store_q[k][h*HALF_W +: HALF_W])
      );
    end
  end

  gpio_wm_sync #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (pad_sync)
  );

  assign pad_out  = store_q[ST_DATA];
  assign pad_oe   = store_q[ST_DIR];
  assign irq_en   = store_q[ST_IEN];
  assign irq_mask = store_q[ST_IMSK];
  assign irq_type = store_q[ST_ITYP];
  assign irq_pol  = store_q[ST_IPOL];
  assign irq_both = store_q[ST_IBTH];
  assign dbnc_en  = store_q[ST_DBNC];

  assign masked_stat = irq_raw & ~store_q[ST_IMSK];

  // Read selection
  always_comb begin
    rd_word = '0;
    if (in_store) begin
      rd_word = pick_half(store_q[slot[IDX_W-1:0]], hi_half);
    end else if (slot == slot_of(OFS_MSTAT)) begin
      rd_word = pick_half(masked_stat, hi_half);
    end else if (slot == slot_of(OFS_RSTAT)) begin
      rd_word = pick_half(irq_raw, hi_half);
    end else if (slot == slot_of(OFS_EXT)) begin
      rd_word = pick_half(pad_sync, hi_half);
    end else if (slot == slot_of(OFS_VER)) begin
      rd_word = hi_half ? '0 : VERSION_ID;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      rsp_rdata <= rd_acc ? rd_word : '0;
    end
  end

  // End-of-interrupt clear pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_clr <= '0;
    end else if (wr_acc && slot == slot_of(OFS_EOI)) begin
      eoi_clr <= hi_half ? {wr_en_bits & wr_val_bits, {HALF_W{1'b0}}}
                         : {{HALF_W{1'b0}}, wr_en_bits & wr_val_bits};
    end else begin
      eoi_clr <= '0;
    end
  end
endmodule

// File: rtl/gpio_wmask_regs_chk.sv
module gpio_wmask_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [31:0]       pad_out,
  input logic [31:0]       pad_oe,
  input logic [31:0]       eoi_clr
);
  localparam int SW = ADDR_W - 3;
  logic [SW-1:0] slot;
  logic          wr;
  assign slot = req_addr[ADDR_W-1:3];
  assign wr   = req_valid && req_write;

  // R8
  eoi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_clr != 32'h0) |-> $past(wr && slot == SW'(12)));

  // R10
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R5
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && slot == SW'(1)) |=> $stable(pad_oe));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && slot == SW'(0)) |=> $stable(pad_out));

  // R2
  zero_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && slot == SW'(0) && req_wdata[31:16] == 16'h0) |=> $stable(pad_out));
endmodule

bind gpio_wmask_regs gpio_wmask_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .eoi_clr  (eoi_clr)
);

// File: tb/sim_gpio_wmask_regs.sv
module sim_gpio_wmask_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0, pad_in = '0, irq_raw = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata, pad_out, pad_oe, irq_en, irq_mask, irq_type;
  logic [31:0] irq_pol, irq_both, dbnc_en, eoi_clr;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  gpio_wmask_regs u0 (.*);

  // {is_write, addr, wdata, expected read}
  localparam int NV = 22;
  localparam logic [72:0] TBL [NV] = '{
    {1'b1, 8'h08, 32'hFFFF_00F0, 32'h0},       // R2 R4 dir lo
    {1'b0, 8'h08, 32'h0, 32'h0000_00F0},
    {1'b1, 8'h08, 32'h0003_FFFF, 32'h0},       // R2 only bits 0,1 enabled
    {1'b0, 8'h08, 32'h0, 32'h0000_00F3},
    {1'b1, 8'h0C, 32'h8000_8000, 32'h0},       // R3 pin 31
    {1'b0, 8'h0C, 32'h0, 32'h0000_8000},
    {1'b1, 8'h08, 32'h0000_0000, 32'h0},       // R2 no enables
    {1'b0, 8'h08, 32'h0, 32'h0000_00F3},
    {1'b1, 8'h10, 32'hFFFF_1234, 32'h0},       // R4 ien
    {1'b0, 8'h10, 32'h0, 32'h0000_1234},
    {1'b0, 8'h14, 32'h0, 32'h0000_0000},       // R3 other half untouched
    {1'b1, 8'h38, 32'h00FF_00AA, 32'h0},       // R4 debounce
    {1'b0, 8'h38, 32'h0, 32'h0000_00AA},
    {1'b1, 8'h30, 32'hFFFF_5555, 32'h0},       // R4 both-edge
    {1'b1, 8'h34, 32'hFFFF_0001, 32'h0},
    {1'b0, 8'h34, 32'h0, 32'h0000_0001},
    {1'b1, 8'h20, 32'hFFFF_0F0F, 32'h0},       // R4 type
    {1'b1, 8'h28, 32'hFFFF_F0F0, 32'h0},       // R4 polarity
    {1'b0, 8'h2C, 32'h0, 32'h0000_0000},
    {1'b0, 8'h78, 32'h0, 32'h0100_0C2B},       // R9 version
    {1'b0, 8'h7C, 32'h0, 32'h0000_0000},       // R9 unmapped
    {1'b0, 8'h40, 32'h0, 32'h0000_0000}        // R9 unmapped
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic        v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 irq_en", irq_en, 32'h0);
    bus_read(8'h00, rd, v);
    check("R1 data read", rd, 32'h0);
    check("R10 read valid", {31'h0, v}, 32'h1);
    check("R10 ready", {31'h0, req_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][72]) bus_write(TBL[i][71:64], TBL[i][63:32]);
      else begin
        bus_read(TBL[i][71:64], rd, v);
        check($sformatf("R2/R3/R4/R9 row %0d", i), rd, TBL[i][31:0]);
      end
    end

    // R5 pad drive
    check("R5 pad_oe", pad_oe, 32'h8000_00F3);
    bus_write(8'h00, 32'hFFFF_00FF);
    bus_write(8'h04, 32'hFFFF_8001);
    check("R5 pad_out", pad_out, 32'h8001_00FF);
    bus_write(8'h04, 32'h0001_0000);
    check("R2 clear single pin 16", pad_out, 32'h8000_00FF);
    check("R10 no response after write", {31'h0, rsp_valid}, 32'h0);

    // R11 config outputs
    check("R11 irq_en", irq_en, 32'h0000_1234);
    check("R11 dbnc_en", dbnc_en, 32'h0000_00AA);
    check("R11 irq_both", irq_both, 32'h0001_5555);
    check("R11 irq_type", irq_type, 32'h0000_0F0F);
    check("R11 irq_pol", irq_pol, 32'h0000_F0F0);

    // R6 synchronised pads
    @(negedge clk); pad_in = 32'hA5A5_3C3C;
    repeat (2) @(negedge clk);
    bus_read(8'h70, rd, v);
    check("R6 ext lo", rd, 32'h0000_3C3C);
    bus_read(8'h74, rd, v);
    check("R6 ext hi", rd, 32'h0000_A5A5);

    // R7 status
    irq_raw = 32'h0003_FFFF;
    bus_write(8'h18, 32'hFFFF_00F0);
    bus_write(8'h1C, 32'hFFFF_0001);
    check("R11 irq_mask", irq_mask, 32'h0001_00F0);
    bus_read(8'h58, rd, v);
    check("R7 raw lo", rd, 32'h0000_FFFF);
    bus_read(8'h50, rd, v);
    check("R7 masked lo", rd, 32'h0000_FF0F);
    bus_read(8'h54, rd, v);
    check("R7 masked hi", rd, 32'h0000_0002);

    // R8 end-of-interrupt pulse
    bus_write(8'h60, 32'h0005_000F);
    check("R8 pulse lo", eoi_clr, 32'h0000_0005);
    @(negedge clk);
    check("R8 pulse ends", eoi_clr, 32'h0);
    bus_write(8'h64, 32'h0001_0003);
    check("R8 pulse hi", eoi_clr, 32'h0001_0000);
    bus_read(8'h60, rd, v);
    check("R8 reads zero", rd, 32'h0);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 pad_oe after reset", pad_oe, 32'h0);
    check("R1 pad_out after reset", pad_out, 32'h0);
    rst_n = 1'b1;
    bus_read(8'h10, rd, v);
    check("R1 ien read after reset", rd, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule